// File: doc/BRIEF.md
# Memory Region Size Probe

This block finds out whether a memory region holds working RAM and, if it does, how large that RAM is. It is a small sequencer that owns a word-wide memory master port with a byte address, write data, a write enable, a read strobe and read data that comes back exactly one cycle after the strobe. A single-cycle start pulse launches a probe. Some cycles later a single-cycle done pulse appears, and the size output then carries the detected size in bytes, or zero when no working RAM answered.

The probe first saves the two lowest words of the region. It then writes two complementary patterns to the two words and reads the first one back. Writing the second word before the read puts a different value on the data bus, so an unpopulated bus that still holds the last value cannot pass for memory. The patterns are then swapped and the check is repeated. To size the region, a test offset starts at 4 bytes and doubles on each step. At each step the probe reads the word at the test offset, writes its complement to word 0, and reads both back. When the two reads are equal, the test address has wrapped onto word 0, and that offset is the size. The search stops at a caller-supplied maximum. Whatever the outcome, the two saved words are written back, so nothing above the first eight bytes is ever written.

Top module: `memsize_probe`

## Requirements
- R1: After every probe, whatever the outcome, the words at byte addresses 0 and 4 hold the values they held before the start pulse, and the last two bus cycles before done are writes of those words.
- R2: The first presence pass writes 0x5555AAAA to address 0, then 0xAAAA5555 to address 4, and then reads address 0. If the value read is not 0x5555AAAA, the reported size is 0.
- R3: The second presence pass writes 0xAAAA5555 to address 0, then 0x5555AAAA to address 4, and then reads address 0. If the value read is not 0xAAAA5555, the reported size is 0.
- R4: For working RAM of power-of-two size N (8 bytes or more) and a maximum M greater than N, the reported size is N. It is found as the first offset in the sequence 4, 8, 16, ... whose word aliases address 0.
- R5: If the test offset reaches or passes the maximum M before a wrap is seen, the reported size is M. This includes an M that is not a power of two, and an M of 4 or less.
- R6: The block never writes to any byte address other than 0 and 4.
- R7: busy_o rises in the cycle after an accepted start and stays high through the done cycle. done_o lasts exactly one cycle, and size_o holds the result from the done cycle until the next done.
- R8: A start pulse that arrives while busy_o is high is ignored. The running probe keeps its maximum, gives one done pulse and returns its own result.
- R9: While the block is idle, the read strobe and write enable stay low, and they are never high in the same cycle.
- R10: During and right after reset, busy_o, done_o, mem_we_o and mem_re_o are low and size_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Single-cycle pulse that launches a probe |
| max_size_i | input | ADDR_W | Upper bound of the search in bytes, captured at start |
| busy_o | output | 1 | High while a probe is running |
| done_o | output | 1 | Single-cycle pulse at the end of a probe |
| size_o | output | ADDR_W | Detected size in bytes (0 when no RAM is present) |
| mem_addr_o | output | ADDR_W | Byte address of the memory access |
| mem_wdata_o | output | DATA_W | Write data |
| mem_we_o | output | 1 | Write enable |
| mem_re_o | output | 1 | Read strobe; data returns the next cycle |
| mem_rdata_i | input | DATA_W | Read data, valid one cycle after mem_re_o |

## Verification
A sequencer that leaves the wrong state shows up on the bus in the very next cycle: as a write to an address above 4, as a strobe while idle, or as a done pulse that is not preceded by the two restore writes. Faults like these are flagged at the cycle they occur. A wrong offset register or a wrong compare shows up only at done, as a size that differs from min(N, M), from M, or from 0. The bench runs each memory model to completion and compares size_o against the value in its table. It also checks, through its own memory model, that the two low words are back to their original contents before the next probe starts.

// File: rtl/msp_pkg.sv
package msp_pkg;

  typedef enum logic [4:0] {
    ST_IDLE,
    ST_SV0,    // read word 0
    ST_SV4,    // capture word 0, read word 4
    ST_SVCAP,  // capture word 4
    ST_A_W0,
    ST_A_W4,
    ST_A_RD,
    ST_A_CMP,
    ST_B_W0,
    ST_B_W4,
    ST_B_RD,
    ST_B_CMP,
    ST_L_CHK,  // compare offset against limit
    ST_L_RDT,  // read test word
    ST_L_FLIP, // write complement to word 0
    ST_L_RD0,  // read word 0
    ST_L_RDX,  // capture word 0, read test word
    ST_L_CMP,  // compare both reads
    ST_RS0,
    ST_RS4,
    ST_DONE
  } st_e;

endpackage

// File: rtl/msp_ctrl.sv
module msp_ctrl
  import msp_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic pres_fail,
  input  logic limit_hit,
  input  logic wrap_hit,
  output st_e  state
);

  st_e nxt;

  always_comb begin
    nxt = state;
    unique case (state)
      ST_IDLE:   if (start_i) nxt = ST_SV0;
      ST_SV0:    nxt = ST_SV4;
      ST_SV4:    nxt = ST_SVCAP;
      ST_SVCAP:  nxt = ST_A_W0;
      ST_A_W0:   nxt = ST_A_W4;
      ST_A_W4:   nxt = ST_A_RD;
      ST_A_RD:   nxt = ST_A_CMP;
      ST_A_CMP:  nxt = pres_fail ? ST_RS0 : ST_B_W0;
      ST_B_W0:   nxt = ST_B_W4;
      ST_B_W4:   nxt = ST_B_RD;
      ST_B_RD:   nxt = ST_B_CMP;
      ST_B_CMP:  nxt = pres_fail ? ST_RS0 : ST_L_CHK;
      ST_L_CHK:  nxt = limit_hit ? ST_RS0 : ST_L_RDT;
      ST_L_RDT:  nxt = ST_L_FLIP;
      ST_L_FLIP: nxt = ST_L_RD0;
      ST_L_RD0:  nxt = ST_L_RDX;
      ST_L_RDX:  nxt = ST_L_CMP;
      ST_L_CMP:  nxt = wrap_hit ? ST_RS0 : ST_L_CHK;
      ST_RS0:    nxt = ST_RS4;
      ST_RS4:    nxt = ST_DONE;
      ST_DONE:   nxt = ST_IDLE;
      default:   nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= nxt;
  end

endmodule

// File: rtl/msp_step.sv
module msp_step
  import msp_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  st_e               state,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] max_size_i,
  input  logic              pres_fail,
  input  logic              wrap_hit,
  output logic              limit_hit,
  output logic [ADDR_W-1:0] ofs_addr,
  output logic [ADDR_W-1:0] max_q,
  output logic [ADDR_W-1:0] size_q
);

  // one spare bit so doubling never wraps to zero
  localparam int OFS_W = ADDR_W + 1;
  localparam logic [OFS_W-1:0] OFS_FIRST = OFS_W'(4);

  logic [OFS_W-1:0] ofs_q;

  function automatic logic [OFS_W-1:0] next_ofs(input logic [OFS_W-1:0] o);
    return {o[OFS_W-2:0], 1'b0};
  endfunction

  function automatic logic reached(input logic [OFS_W-1:0] o,
                                   input logic [ADDR_W-1:0] lim);
    return o >= {1'b0, lim};
  endfunction

  logic start_acc;
  assign start_acc = (state == ST_IDLE) && start_i;
  assign limit_hit = (state == ST_L_CHK) && reached(ofs_q, max_q);
  assign ofs_addr  = ofs_q[ADDR_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ofs_q  <= OFS_FIRST;
      max_q  <= '0;
      size_q <= '0;
    end else begin
      if (start_acc) begin
        ofs_q <= OFS_FIRST;
        max_q <= max_size_i;
      end else if ((state == ST_L_CMP) && !wrap_hit) begin
        ofs_q <= next_ofs(ofs_q);
      end
      if (pres_fail)      size_q <= '0;
      else if (limit_hit) size_q <= max_q;
      else if (wrap_hit)  size_q <= ofs_q[ADDR_W-1:0];
    end
  end

endmodule

// File: rtl/msp_bus.sv
module msp_bus
  import msp_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  st_e               state,
  input  logic [ADDR_W-1:0] ofs_addr,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  output logic              mem_we_o,
  output logic              mem_re_o,
  output logic              pres_fail,
  output logic              wrap_hit
);

  localparam int Q = DATA_W / 4;
  // upper half 0101..., lower half 1010...
  localparam logic [DATA_W-1:0] PAT_A = {{Q{2'b01}}, {Q{2'b10}}};
  localparam logic [DATA_W-1:0] PAT_B = ~PAT_A;
  localparam logic [ADDR_W-1:0] ADR_W1 = ADDR_W'(4);

  logic [DATA_W-1:0] save0_q, save1_q, a0_q;

  function automatic logic [DATA_W-1:0] flip(input logic [DATA_W-1:0] d);
    return ~d;
  endfunction

  always_comb begin
    mem_addr_o  = '0;
    mem_wdata_o = '0;
    mem_we_o    = 1'b0;
    mem_re_o    = 1'b0;
    unique case (state)
      ST_SV0:    mem_re_o = 1'b1;
      ST_SV4:    begin mem_re_o = 1'b1; mem_addr_o = ADR_W1; end
      ST_A_W0:   begin mem_we_o = 1'b1; mem_wdata_o = PAT_A; end
      ST_A_W4:   begin mem_we_o = 1'b1; mem_wdata_o = PAT_B; mem_addr_o = ADR_W1; end
      ST_A_RD:   mem_re_o = 1'b1;
      ST_B_W0:   begin mem_we_o = 1'b1; mem_wdata_o = PAT_B; end
      ST_B_W4:   begin mem_we_o = 1'b1; mem_wdata_o = PAT_A; mem_addr_o = ADR_W1; end
      ST_B_RD:   mem_re_o = 1'b1;
      ST_L_RDT:  begin mem_re_o = 1'b1; mem_addr_o = ofs_addr; end
      ST_L_FLIP: begin mem_we_o = 1'b1; mem_wdata_o = flip(mem_rdata_i); end
      ST_L_RD0:  mem_re_o = 1'b1;
      ST_L_RDX:  begin mem_re_o = 1'b1; mem_addr_o = ofs_addr; end
      ST_RS0:    begin mem_we_o = 1'b1; mem_wdata_o = save0_q; end
      ST_RS4:    begin mem_we_o = 1'b1; mem_wdata_o = save1_q; mem_addr_o = ADR_W1; end
      default:   ;
    endcase
  end

  assign pres_fail = ((state == ST_A_CMP) && (mem_rdata_i != PAT_A)) ||
                     ((state == ST_B_CMP) && (mem_rdata_i != PAT_B));
  assign wrap_hit  = (state == ST_L_CMP) && (a0_q == mem_rdata_i);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      save0_q <= '0;
      save1_q <= '0;
      a0_q    <= '0;
    end else begin
      if (state == ST_SV4)   save0_q <= mem_rdata_i;
      if (state == ST_SVCAP) save1_q <= mem_rdata_i;
      if (state == ST_L_RDX) a0_q    <= mem_rdata_i;
    end
  end

endmodule

// File: rtl/memsize_probe.sv
module memsize_probe
  import msp_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] max_size_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [ADDR_W-1:0] size_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  output logic              mem_we_o,
  output logic              mem_re_o,
  input  logic [DATA_W-1:0] mem_rdata_i
);

  st_e               state;
  logic              pres_fail;
  logic              limit_hit;
  logic              wrap_hit;
  logic [ADDR_W-1:0] ofs_addr;
  logic [ADDR_W-1:0] max_q;
  logic [ADDR_W-1:0] size_q;

  msp_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .pres_fail (pres_fail),
    .limit_hit (limit_hit),
    .wrap_hit  (wrap_hit),
    .state     (state)
  );

  msp_step #(.ADDR_W(ADDR_W)) u_step (
    .clk        (clk),
    .rst_n      (rst_n),
    .state      (state),
    .start_i    (start_i),
    .max_size_i (max_size_i),
    .pres_fail  (pres_fail),
    .wrap_hit   (wrap_hit),
    .limit_hit  (limit_hit),
    .ofs_addr   (ofs_addr),
    .max_q      (max_q),
    .size_q     (size_q)
  );

  msp_bus #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_bus (
    .clk         (clk),
    .rst_n       (rst_n),
    .state       (state),
    .ofs_addr    (ofs_addr),
    .mem_rdata_i (mem_rdata_i),
    .mem_addr_o  (mem_addr_o),
    .mem_wdata_o (mem_wdata_o),
    .mem_we_o    (mem_we_o),
    .mem_re_o    (mem_re_o),
    .pres_fail   (pres_fail),
    .wrap_hit    (wrap_hit)
  );

  assign busy_o = (state != ST_IDLE);
  assign done_o = (state == ST_DONE);
  assign size_o = size_q;

endmodule

// File: rtl/msp_checker.sv
module msp_checker #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_i,
  input logic              busy_o,
  input logic              done_o,
  input logic [ADDR_W-1:0] size_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic [DATA_W-1:0] mem_wdata_o,
  input logic              mem_we_o,
  input logic              mem_re_o,
  input logic              pres_fail,
  input logic              wrap_hit,
  input logic [ADDR_W-1:0] max_q
);

  // R6
  wr_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we_o |-> (mem_addr_o == ADDR_W'(0) || mem_addr_o == ADDR_W'(4)));

  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (!mem_we_o && !mem_re_o));

  // R9
  we_re_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we_o && mem_re_o));

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> (!done_o && !busy_o));

  // R7
  done_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> busy_o);

  // R1
  restore_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> ($past(mem_we_o) && $past(mem_addr_o) == ADDR_W'(4)));

  // R5
  size_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (size_o <= max_q));

  // R2 R3
  fail_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pres_fail |=> (size_o == '0));

  // R4
  wrap_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_hit |=> ($countones(size_o) == 1));

  // R8
  start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !done_o && start_i) |=> (busy_o && $stable(max_q)));

endmodule

bind memsize_probe msp_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start_i     (start_i),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .size_o      (size_o),
  .mem_addr_o  (mem_addr_o),
  .mem_wdata_o (mem_wdata_o),
  .mem_we_o    (mem_we_o),
  .mem_re_o    (mem_re_o),
  .pres_fail   (pres_fail),
  .wrap_hit    (wrap_hit),
  .max_q       (max_q)
);

// File: tb/sim_memsize_probe.sv
module sim_memsize_probe;

  localparam int AW = 32;
  localparam int DW = 32;
  localparam logic [31:0] STUCK = 32'h5555AAAA;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start_i = 1'b0;
  logic [AW-1:0] max_size_i = '0;
  logic          busy_o, done_o, mem_we_o, mem_re_o;
  logic [AW-1:0] size_o, mem_addr_o;
  logic [DW-1:0] mem_wdata_o;
  logic [DW-1:0] mem_rdata_i = '0;

  always #10 clk = ~clk;

  memsize_probe #(.ADDR_W(AW), .DATA_W(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .max_size_i(max_size_i),
    .busy_o(busy_o), .done_o(done_o), .size_o(size_o),
    .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o),
    .mem_we_o(mem_we_o), .mem_re_o(mem_re_o), .mem_rdata_i(mem_rdata_i)
  );

  // memory model: kind 0 = nothing (bus floats to last driven value),
  // 1 = working RAM of nbytes, 2 = RAM with bits stuck low
  int          kind = 1;
  int          nbytes = 64;
  logic        load_req = 1'b0;
  logic [31:0] v0 = '0, v1 = '0;
  logic [31:0] mem [0:255];
  logic [31:0] bus_last = '0;
  int          stray = 0;
  int          done_cnt = 0;

  function automatic int widx(input logic [AW-1:0] a);
    return int'((a >> 2) & AW'((nbytes >> 2) - 1));
  endfunction

  always @(posedge clk) begin
    if (load_req) begin
      for (int i = 0; i < 256; i++) mem[i] <= 32'h3C000000 + 32'(i * 7);
      mem[0] <= v0;
      mem[1] <= v1;
    end else if (mem_we_o) begin
      bus_last <= mem_wdata_o;
      if (mem_addr_o > 7) stray <= stray + 1;
      if (kind == 1) mem[widx(mem_addr_o)] <= mem_wdata_o;
      else if (kind == 2) mem[widx(mem_addr_o)] <= mem_wdata_o & STUCK;
    end
    if (mem_re_o) mem_rdata_i <= (kind == 0) ? bus_last : mem[widx(mem_addr_o)];
    if (done_o) done_cnt <= done_cnt + 1;
  end

  int checks = 0;
  int failures = 0;
  int cyc = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=0x%08h expected=0x%08h", cyc, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  // {kind, mem bytes, max size, expected size}
  localparam int NV = 9;
  localparam logic [37:0] VEC [0:NV-1] = '{
    {2'd1, 12'd64,   12'd256,  12'd64 },  // R4
    {2'd1, 12'd256,  12'd256,  12'd256},  // R5 offset reaches max
    {2'd1, 12'd1024, 12'd256,  12'd256},  // R5
    {2'd0, 12'd64,   12'd256,  12'd0  },  // R2 floating bus
    {2'd1, 12'd8,    12'd1024, 12'd8  },  // R4 smallest
    {2'd1, 12'd16,   12'd24,   12'd16 },  // R4 non-power max
    {2'd1, 12'd1024, 12'd24,   12'd24 },  // R5 non-power max
    {2'd1, 12'd512,  12'd4,    12'd4  },  // R5 max of 4
    {2'd2, 12'd64,   12'd256,  12'd0  }   // R3 stuck bits
  };

  task automatic run_probe(input int k, input int nb, input int mx,
                           input int expv, input bit poke_mid);
    int waited;
    int d0;
    kind = k;
    nbytes = nb;
    v0 = 32'hC0DE0000 + 32'(nb + k);
    v1 = 32'h0BAD0000 + 32'(mx);
    @(negedge clk) load_req = 1'b1;
    @(negedge clk) load_req = 1'b0;
    d0 = done_cnt;
    max_size_i = AW'(mx);
    start_i = 1'b1;
    @(negedge clk) start_i = 1'b0;
    // R7: busy in the cycle after the accepted start
    chk(busy_o == 1'b1, "R7 busy after start", 32'(busy_o), 32'd1);
    waited = 0;
    while (!done_o && waited < 3000) begin
      if (poke_mid && waited == 5) begin
        max_size_i = AW'(8);
        start_i = 1'b1;
      end else begin
        start_i = 1'b0;
      end
      @(negedge clk);
      waited++;
    end
    start_i = 1'b0;
    chk(done_o == 1'b1, "R7 done seen", 32'(done_o), 32'd1);
    chk(size_o == AW'(expv), (k == 0) ? "R2 size" : (k == 2) ? "R3 size" :
        (expv == mx) ? "R5 size" : "R4 size", size_o, 32'(expv));
    @(negedge clk);
    chk(!done_o && !busy_o, "R7 single done pulse", {30'd0, done_o, busy_o}, 32'd0);
    chk(size_o == AW'(expv), "R7 size held", size_o, 32'(expv));
    chk(done_cnt == d0 + 1, poke_mid ? "R8 one done" : "R7 one done",
        32'(done_cnt - d0), 32'd1);
    chk(stray == 0, "R6 no stray writes", 32'(stray), 32'd0);
    if (k == 1) begin
      chk(mem[0] == v0, "R1 word0 restored", mem[0], v0);
      chk(mem[1] == v1, "R1 word4 restored", mem[1], v1);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    chk({busy_o, done_o, mem_we_o, mem_re_o} == 4'b0, "R10 reset controls",
        32'({busy_o, done_o, mem_we_o, mem_re_o}), 32'd0);
    chk(size_o == '0, "R10 reset size", size_o, 32'd0);
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);
    chk({busy_o, done_o, mem_we_o, mem_re_o} == 4'b0, "R10 after reset",
        32'({busy_o, done_o, mem_we_o, mem_re_o}), 32'd0);
    // R9 idle stays quiet
    repeat (4) begin
      @(negedge clk);
      chk(!mem_we_o && !mem_re_o, "R9 idle bus", 32'({mem_we_o, mem_re_o}), 32'd0);
    end

    for (int i = 0; i < NV; i++)
      run_probe(int'(VEC[i][37:36]), int'(VEC[i][35:24]), int'(VEC[i][23:12]),
                int'(VEC[i][11:0]), 1'b0);

    // R8: start pulse mid-probe with a different max must not disturb the run
    run_probe(1, 128, 512, 128, 1'b1);
    // R4 again after an ignored start, plus the largest model
    run_probe(1, 1024, 1024, 1024, 1'b0);
    run_probe(1, 512, 1024, 512, 1'b0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule